// File: doc/BRIEF.md
# Policy-Selectable Two-Way Data Cache

This block is a two-way set-associative data cache controller. Each line holds eight 32-bit words. A request from the core carries three things in the same cycle: a set index taken from the virtual address, a tag taken from the physical address, and a 2-bit page attribute. The attribute picks one of four write policies for that access alone. Uncached accesses skip the arrays entirely. Write-back stores keep their data on chip until the line is evicted. The two write-through flavours send every store to memory, and they differ only in whether a store miss allocates a line.

The memory side uses a word-granular request/acknowledge handshake. A line refill is eight read beats. A dirty eviction is eight write beats. A write-through or uncached store is a single write beat with byte enables.

Every tag entry keeps an even-parity bit, and every data byte keeps its own parity bit. A mismatch on a tag, or on the word a load reads, raises a sticky error flag and makes the access take the miss path.

The core holds its request until `respValid` pulses. It may present the next request one cycle after the pulse at the earliest.

Top module: `polcache`

## Requirements
- R1: A line refill issues eight read beats, one per word, to word addresses {tag, index, 0} through {tag, index, 7} in ascending order. The memory word address is {tag, index, word}, with the word in bits 2:0.
- R2: Policy code 00 (uncached) makes exactly one memory beat at the request address, a read or a write. It leaves all cache contents unchanged, so a later cached load to a cached line still returns the on-chip copy.
- R3: Under policy 01 (write-back), a store hit writes only the cache, makes no memory beat, and marks the line dirty.
- R4: Under policy 01, a store miss refills the line first and then applies the store as a hit.
- R5: Under policy 10 (write-through, allocate), a store hit updates the line and makes one memory write beat, and the dirty bit is left as it was. A store miss refills first and then does the same.
- R6: Under policy 11 (write-through, no allocate), a store hit behaves as under R5. A store miss makes one memory write beat and allocates nothing, so a later load to that line misses.
- R7: A cached load that hits returns the stored word with no memory traffic. A load miss refills the line and then returns the word.
- R8: The victim in a set is an invalid way, with way 0 taken before way 1. When both ways are valid, the victim is the least recently used way of the set, tracked by one bit per set.
- R9: A dirty victim is written back as eight write beats of its old line, words 0 to 7, before the refill's first read. A clean victim causes no write.
- R10: `respValid` is a one-cycle pulse. Count from the capture edge. A load hit completes after 1 cycle. Each memory beat adds 1 cycle. A refill adds 1 more cycle for the repeated lookup. Uncached accesses take 1 cycle per beat only.
- R11: `parityErr` is low out of reset and stays high once set. Traffic with consistent parity never sets it.
- R12: Bit i of `reqBe` and of `memBe` enables byte i (bits 8i+7:8i). A store changes only the enabled bytes in the cache and in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until respValid |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqPolicy | input | 2 | 00 uncached, 01 write-back, 10 write-through allocate, 11 write-through no allocate |
| reqTag | input | TAG_W | Physical tag |
| reqIndex | input | IDX_W | Virtual set index |
| reqWord | input | 3 | Word within the line |
| reqBe | input | 4 | Store byte enables |
| reqWdata | input | 32 | Store data |
| respValid | output | 1 | One-cycle completion pulse |
| respData | output | 32 | Load result, valid with respValid |
| parityErr | output | 1 | Sticky parity error flag |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat |
| memAddr | output | TAG_W+IDX_W+3 | Word address {tag, index, word} |
| memBe | output | 4 | Byte enables of a write beat |
| memWdata | output | 32 | Write beat data |
| memRdata | input | 32 | Read beat data, valid with memAck |
| memAck | input | 1 | Beat accepted in this cycle |

## Verification
The tightest overlap comes on the last beat of a refill. In that one cycle the final data word is written while the tag, valid bit and cleared dirty bit of the victim way are installed. The next cycle's lookup must then see a consistent line. Store misses under policies 01 and 10 provoke this directly, because the refilled line is hit at once by the pending store. The store's merged bytes and, for policy 10, its memory write beat are judged against a behavioural cache model that also predicts the exact cycle of the response. A second overlap comes on a write-back store hit, which updates data, dirty state and recency in the same cycle. It is judged later by which way a following miss evicts and by the contents of that eviction.

// File: rtl/polcache_pkg.sv
package polcache_pkg;
  localparam int LINE_WORDS = 8;
  localparam int WOFF_W = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {
    POL_UNC = 2'b00,
    POL_WB  = 2'b01,
    POL_WTA = 2'b10,
    POL_WTN = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    SRC_REQ   = 2'd0,
    SRC_EVICT = 2'd1,
    SRC_FILL  = 2'd2
  } memSrc_e;

  typedef struct packed {
    logic              capReq;
    logic              lookup;
    logic              storeHit;
    logic              markDirty;
    logic              touchLru;
    logic              holdVictim;
    logic              fillWord;
    logic              fillDone;
    logic              takeHit;
    logic              takeMem;
    memSrc_e           memSrc;
    logic [WOFF_W-1:0] beat;
  } strobes_t;

  function automatic logic [3:0] byteParity(input logic [31:0] w);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^w[8*b +: 8];
    return p;
  endfunction
endpackage

// File: rtl/polcache_dp.sv
module polcache_dp
  import polcache_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobes_t                         ctrl,
  input  logic                             reqWrite,
  input  logic [1:0]                       reqPolicy,
  input  logic [TAG_W-1:0]                 reqTag,
  input  logic [IDX_W-1:0]                 reqIndex,
  input  logic [WOFF_W-1:0]                reqWord,
  input  logic [3:0]                       reqBe,
  input  logic [31:0]                      reqWdata,
  output logic                             opWrite,
  output policy_e                          opPolicy,
  output logic                             hit,
  output logic                             victimDirty,
  output logic [31:0]                      rspData,
  output logic                             parityErr,
  output logic [TAG_W+IDX_W+WOFF_W-1:0]    memAddr,
  output logic [3:0]                       memBe,
  output logic [31:0]                      memWdata,
  input  logic [31:0]                      memRdata
);
  localparam int SETS = 1 << IDX_W;
  localparam int WAYS = 2;

  logic [TAG_W-1:0] tagMem  [WAYS][SETS];
  logic             tagPar  [WAYS][SETS];
  logic             vld     [WAYS][SETS];
  logic             drt     [WAYS][SETS];
  logic             lru     [SETS];
  logic [31:0]      dataMem [WAYS][SETS][LINE_WORDS];
  logic [3:0]       dataPar [WAYS][SETS][LINE_WORDS];

  logic [TAG_W-1:0]  tagQ;
  logic [IDX_W-1:0]  idxQ;
  logic [WOFF_W-1:0] wordQ;
  logic [3:0]        beQ;
  logic [31:0]       wdQ;
  logic              vicQ;
  logic [TAG_W-1:0]  vicTagQ;
  logic              errQ;

  logic [WAYS-1:0] wayOk, match, tagBad;
  logic            hitWay, dataBad, vicWay;
  logic [31:0]     rdWord, merged;

  always_ff @(posedge clk) begin
    if (ctrl.capReq) begin
      tagQ     <= reqTag;
      idxQ     <= reqIndex;
      wordQ    <= reqWord;
      beQ      <= reqBe;
      wdQ      <= reqWdata;
      opWrite  <= reqWrite;
      opPolicy <= policy_e'(reqPolicy);
    end
    if (ctrl.holdVictim) begin
      vicQ    <= vicWay;
      vicTagQ <= tagMem[vicWay][idxQ];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    assign tagBad[w] = vld[w][idxQ] && ((^tagMem[w][idxQ]) != tagPar[w][idxQ]);
    assign wayOk[w]  = vld[w][idxQ] && !tagBad[w];
    assign match[w]  = wayOk[w] && (tagMem[w][idxQ] == tagQ);
  end

  assign hitWay  = match[1];
  assign rdWord  = dataMem[hitWay][idxQ][wordQ];
  assign dataBad = (|match) && !opWrite &&
                   (byteParity(rdWord) != dataPar[hitWay][idxQ][wordQ]);
  assign hit     = (|match) && !dataBad;

  always_comb begin
    vicWay      = lru[idxQ];
    victimDirty = drt[lru[idxQ]][idxQ];
    if (dataBad) begin
      vicWay      = hitWay;
      victimDirty = 1'b0;
    end else if (!wayOk[0]) begin
      vicWay      = 1'b0;
      victimDirty = 1'b0;
    end else if (!wayOk[1]) begin
      vicWay      = 1'b1;
      victimDirty = 1'b0;
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++)
      merged[8*b +: 8] = beQ[b] ? wdQ[8*b +: 8] : rdWord[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (ctrl.storeHit) begin
      dataMem[hitWay][idxQ][wordQ] <= merged;
      dataPar[hitWay][idxQ][wordQ] <= byteParity(merged);
    end
    if (ctrl.fillWord) begin
      dataMem[vicQ][idxQ][ctrl.beat] <= memRdata;
      dataPar[vicQ][idxQ][ctrl.beat] <= byteParity(memRdata);
    end
    if (ctrl.fillDone) begin
      tagMem[vicQ][idxQ] <= tagQ;
      tagPar[vicQ][idxQ] <= ^tagQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lru[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) begin
          vld[w][s] <= 1'b0;
          drt[w][s] <= 1'b0;
        end
      end
      errQ    <= 1'b0;
      rspData <= '0;
    end else begin
      if (ctrl.fillDone) begin
        vld[vicQ][idxQ] <= 1'b1;
        drt[vicQ][idxQ] <= 1'b0;
      end
      if (ctrl.markDirty) drt[hitWay][idxQ] <= 1'b1;
      if (ctrl.touchLru)  lru[idxQ] <= ~hitWay;
      if (ctrl.lookup && (dataBad || (|tagBad))) errQ <= 1'b1;
      if (ctrl.takeHit) rspData <= rdWord;
      if (ctrl.takeMem) rspData <= memRdata;
    end
  end

  assign parityErr = errQ;

  always_comb begin
    memAddr  = {tagQ, idxQ, wordQ};
    memBe    = beQ;
    memWdata = wdQ;
    case (ctrl.memSrc)
      SRC_EVICT: begin
        memAddr  = {vicTagQ, idxQ, ctrl.beat};
        memBe    = 4'hF;
        memWdata = dataMem[vicQ][idxQ][ctrl.beat];
      end
      SRC_FILL: begin
        memAddr = {tagQ, idxQ, ctrl.beat};
        memBe   = 4'hF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/polcache_ctl.sv
module polcache_ctl
  import polcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqPolicy,
  input  logic       opWrite,
  input  policy_e    opPolicy,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memAck,
  output strobes_t   ctrl,
  output logic       memReq,
  output logic       memWe,
  output logic       respValid
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_EVICT, ST_FILL, ST_WMEM, ST_UNC, ST_DONE
  } state_e;

  state_e            state, stateNext;
  logic [WOFF_W-1:0] beat;
  logic              lastBeat;

  assign lastBeat = (beat == WOFF_W'(LINE_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      state <= stateNext;
      if ((state == ST_EVICT || state == ST_FILL) && memAck)
        beat <= beat + WOFF_W'(1);
    end
  end

  always_comb begin
    ctrl      = '0;
    ctrl.beat = beat;
    memReq    = 1'b0;
    memWe     = 1'b0;
    respValid = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        ctrl.capReq = 1'b1;
        stateNext   = (policy_e'(reqPolicy) == POL_UNC) ? ST_UNC : ST_LOOK;
      end
      ST_LOOK: begin
        ctrl.lookup = 1'b1;
        if (hit) begin
          ctrl.touchLru = 1'b1;
          if (opWrite) begin
            ctrl.storeHit  = 1'b1;
            ctrl.markDirty = (opPolicy == POL_WB);
            stateNext      = (opPolicy == POL_WB) ? ST_DONE : ST_WMEM;
          end else begin
            ctrl.takeHit = 1'b1;
            stateNext    = ST_DONE;
          end
        end else if (opWrite && opPolicy == POL_WTN) begin
          stateNext = ST_WMEM;
        end else begin
          ctrl.holdVictim = 1'b1;
          stateNext       = victimDirty ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        ctrl.memSrc = SRC_EVICT;
        memReq      = 1'b1;
        memWe       = 1'b1;
        if (memAck && lastBeat) stateNext = ST_FILL;
      end
      ST_FILL: begin
        ctrl.memSrc = SRC_FILL;
        memReq      = 1'b1;
        if (memAck) begin
          ctrl.fillWord = 1'b1;
          if (lastBeat) begin
            ctrl.fillDone = 1'b1;
            stateNext     = ST_LOOK;
          end
        end
      end
      ST_WMEM: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateNext = ST_DONE;
      end
      ST_UNC: begin
        memReq = 1'b1;
        memWe  = opWrite;
        if (memAck) begin
          ctrl.takeMem = !opWrite;
          stateNext    = ST_DONE;
        end
      end
      ST_DONE: begin
        respValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/polcache.sv
module polcache
  import polcache_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [1:0]                    reqPolicy,
  input  logic [TAG_W-1:0]              reqTag,
  input  logic [IDX_W-1:0]              reqIndex,
  input  logic [2:0]                    reqWord,
  input  logic [3:0]                    reqBe,
  input  logic [31:0]                   reqWdata,
  output logic                          respValid,
  output logic [31:0]                   respData,
  output logic                          parityErr,
  output logic                          memReq,
  output logic                          memWe,
  output logic [TAG_W+IDX_W+2:0]        memAddr,
  output logic [3:0]                    memBe,
  output logic [31:0]                   memWdata,
  input  logic [31:0]                   memRdata,
  input  logic                          memAck
);
  localparam int ADDR_W = TAG_W + IDX_W + WOFF_W;

  strobes_t ctrl;
  logic     opWrite, hit, victimDirty;
  policy_e  opPolicy;

  polcache_ctl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPolicy(reqPolicy),
    .opWrite(opWrite), .opPolicy(opPolicy), .hit(hit),
    .victimDirty(victimDirty), .memAck(memAck), .ctrl(ctrl),
    .memReq(memReq), .memWe(memWe), .respValid(respValid)
  );

  polcache_dp #(.TAG_W(TAG_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqWrite(reqWrite),
    .reqPolicy(reqPolicy), .reqTag(reqTag), .reqIndex(reqIndex),
    .reqWord(reqWord), .reqBe(reqBe), .reqWdata(reqWdata),
    .opWrite(opWrite), .opPolicy(opPolicy), .hit(hit),
    .victimDirty(victimDirty), .rspData(respData), .parityErr(parityErr),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata)
  );
endmodule

// File: rtl/polcache_chk.sv
module polcache_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              respValid,
  input logic              parityErr,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);
  // R10: completion is a single-cycle pulse
  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R10: no memory beat is pending while a response is presented
  a_r10_quiet_on_resp: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !memReq);

  // R11: the parity error flag never clears while out of reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> parityErr);

  // R1: an unacknowledged beat keeps its address and direction
  a_r1_beat_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
endmodule

bind polcache polcache_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .respValid(respValid), .parityErr(parityErr),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr)
);

// File: tb/sim_polcache.sv
`timescale 1ns/1ps
module sim_polcache;
  localparam int TAG_W  = 8;
  localparam int IDX_W  = 4;
  localparam int SETS   = 1 << IDX_W;
  localparam int ADDR_W = TAG_W + IDX_W + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN, reqValid, reqWrite;
  logic [1:0]        reqPolicy;
  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIndex;
  logic [2:0]        reqWord;
  logic [3:0]        reqBe;
  logic [31:0]       reqWdata;
  logic              respValid, parityErr, memReq, memWe, memAck;
  logic [31:0]       respData, memWdata, memRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [3:0]        memBe;

  polcache #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPolicy(reqPolicy), .reqTag(reqTag), .reqIndex(reqIndex),
    .reqWord(reqWord), .reqBe(reqBe), .reqWdata(reqWdata),
    .respValid(respValid), .respData(respData), .parityErr(parityErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0;
  int fails  = 0;
  string curReq = "R10";

  typedef struct {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
    logic [3:0]        be;
  } op_t;
  op_t opQ[$];

  logic [31:0]      mem [0:(1<<ADDR_W)-1];
  logic [TAG_W-1:0] mTag   [2][SETS];
  bit               mVld   [2][SETS];
  bit               mDirty [2][SETS];
  bit               mLru   [SETS];
  logic [31:0]      mData  [2][SETS][8];

  function automatic void chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] mergeBe(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  // behavioural memory: acknowledges every beat and compares it with the model
  initial begin
    memAck = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      if (memReq) begin
        op_t e;
        checks++;
        if (opQ.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected beat: actual we=%0b addr=%h expected none",
                   curReq, memWe, memAddr);
        end else begin
          e = opQ.pop_front();
          if (e.we !== memWe || e.addr !== memAddr ||
              (e.we && (e.data !== memWdata || e.be !== memBe))) begin
            fails++;
            $display("FAIL %s beat: actual we=%0b addr=%h data=%h be=%h expected we=%0b addr=%h data=%h be=%h",
                     curReq, memWe, memAddr, memWdata, memBe, e.we, e.addr, e.data, e.be);
          end
        end
        if (memWe) mem[memAddr] = mergeBe(mem[memAddr], memWdata, memBe);
        else memRdata = mem[memAddr];
        memAck = 1'b1;
      end else begin
        memAck = 1'b0;
      end
    end
  end

  task automatic access(string rq, bit wr, logic [1:0] pol, logic [TAG_W-1:0] tg,
                        logic [IDX_W-1:0] ix, logic [2:0] wd, logic [3:0] be,
                        logic [31:0] wdat);
    int lat, hw, v, c;
    bit chkData;
    logic [31:0] expD;
    logic [ADDR_W-1:0] a;
    curReq = rq;
    a = {tg, ix, wd};
    chkData = 0;
    expD = '0;
    if (pol == 2'b00) begin
      lat = 1;
      if (wr) opQ.push_back('{1'b1, a, wdat, be});
      else begin
        opQ.push_back('{1'b0, a, 32'h0, 4'hF});
        expD = mem[a];
        chkData = 1;
      end
    end else begin
      lat = 1;
      hw = -1;
      for (int w = 0; w < 2; w++) if (mVld[w][ix] && mTag[w][ix] == tg) hw = w;
      if (hw < 0 && wr && pol == 2'b11) begin
        opQ.push_back('{1'b1, a, wdat, be});
        lat += 1;
      end else begin
        if (hw < 0) begin
          v = !mVld[0][ix] ? 0 : (!mVld[1][ix] ? 1 : int'(mLru[ix]));
          if (mVld[v][ix] && mDirty[v][ix]) begin
            for (int i = 0; i < 8; i++)
              opQ.push_back('{1'b1, {mTag[v][ix], ix, 3'(i)}, mData[v][ix][i], 4'hF});
            lat += 8;
          end
          for (int i = 0; i < 8; i++) begin
            opQ.push_back('{1'b0, {tg, ix, 3'(i)}, 32'h0, 4'hF});
            mData[v][ix][i] = mem[{tg, ix, 3'(i)}];
          end
          lat += 9;
          mTag[v][ix] = tg;
          mVld[v][ix] = 1;
          mDirty[v][ix] = 0;
          hw = v;
        end
        mLru[ix] = (hw == 0);
        if (wr) begin
          mData[hw][ix][wd] = mergeBe(mData[hw][ix][wd], wdat, be);
          if (pol == 2'b01) mDirty[hw][ix] = 1;
          else begin
            opQ.push_back('{1'b1, a, wdat, be});
            lat += 1;
          end
        end else begin
          expD = mData[hw][ix][wd];
          chkData = 1;
        end
      end
    end
    reqValid = 1'b1; reqWrite = wr; reqPolicy = pol; reqTag = tg;
    reqIndex = ix; reqWord = wd; reqBe = be; reqWdata = wdat;
    c = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      c++;
      if (respValid || c > 200) break;
    end
    chk("R10", {rq, " response cycle"}, c, 1 + lat);
    if (chkData) chk(rq, "load data", respData, expD);
    chk(rq, "beats left over", opQ.size(), 0);
    opQ.delete();
    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "pulse width", {31'b0, respValid}, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A17C3E1;
    for (int s = 0; s < SETS; s++) begin
      mLru[s] = 0;
      for (int w = 0; w < 2; w++) begin mVld[w][s] = 0; mDirty[w][s] = 0; end
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqPolicy = 2'b00;
    reqTag = '0; reqIndex = '0; reqWord = '0; reqBe = '0; reqWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset respValid", {31'b0, respValid}, 32'h0);
    chk("R11", "reset parityErr", {31'b0, parityErr}, 32'h0);
    chk("R1", "reset memReq", {31'b0, memReq}, 32'h0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);

    access("R7", 0, 2'b01, 8'h05, 4'd1, 3'd2, 4'hF, 32'h0);          // clean refill (R1)
    access("R7", 0, 2'b01, 8'h05, 4'd1, 3'd3, 4'hF, 32'h0);          // load hit
    access("R3", 1, 2'b01, 8'h05, 4'd1, 3'd2, 4'hF, 32'hA5A5_5A5A);  // WB hit
    access("R3", 0, 2'b01, 8'h05, 4'd1, 3'd2, 4'hF, 32'h0);
    access("R8", 0, 2'b01, 8'h06, 4'd1, 3'd0, 4'hF, 32'h0);          // fills way 1
    access("R9", 0, 2'b01, 8'h07, 4'd1, 3'd4, 4'hF, 32'h0);          // dirty way 0 evicted
    access("R4", 1, 2'b01, 8'h03, 4'd2, 3'd5, 4'hF, 32'h1234_5678);  // WB miss
    access("R4", 0, 2'b01, 8'h03, 4'd2, 3'd5, 4'hF, 32'h0);
    access("R5", 1, 2'b10, 8'h04, 4'd3, 3'd1, 4'b0110, 32'hDEAD_BEEF);
    access("R12", 0, 2'b10, 8'h04, 4'd3, 3'd1, 4'hF, 32'h0);
    access("R5", 1, 2'b10, 8'h04, 4'd3, 3'd1, 4'b0001, 32'h0000_0077);
    access("R6", 1, 2'b11, 8'h09, 4'd4, 3'd0, 4'hF, 32'hCAFE_F00D);  // no allocate
    access("R6", 0, 2'b11, 8'h09, 4'd4, 3'd0, 4'hF, 32'h0);          // still misses
    access("R6", 1, 2'b11, 8'h09, 4'd4, 3'd0, 4'b1000, 32'h1100_0000);
    access("R2", 1, 2'b00, 8'h09, 4'd4, 3'd0, 4'hF, 32'h0BAD_0BAD);
    access("R2", 0, 2'b01, 8'h09, 4'd4, 3'd0, 4'hF, 32'h0);          // stale copy
    access("R2", 0, 2'b00, 8'h09, 4'd4, 3'd0, 4'hF, 32'h0);          // memory value
    access("R8", 0, 2'b01, 8'h01, 4'd5, 3'd0, 4'hF, 32'h0);
    access("R8", 0, 2'b01, 8'h02, 4'd5, 3'd0, 4'hF, 32'h0);
    access("R8", 0, 2'b01, 8'h01, 4'd5, 3'd6, 4'hF, 32'h0);
    access("R8", 0, 2'b01, 8'h03, 4'd5, 3'd0, 4'hF, 32'h0);          // tag 2 is LRU
    access("R8", 0, 2'b01, 8'h01, 4'd5, 3'd7, 4'hF, 32'h0);          // tag 1 still hits

    for (int n = 0; n < 400; n++) begin
      logic [3:0] be;
      be = 4'($urandom_range(1, 15));
      access("R12", 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             8'($urandom_range(1, 4)), 4'($urandom_range(0, 2)),
             3'($urandom_range(0, 7)), be, $urandom());
    end

    chk("R11", "parityErr after clean traffic", {31'b0, parityErr}, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule